// File: doc/BRIEF.md
# Rotating Unit-Element Selector for a Multi-Level Noise-Shaping DAC

This block sits between a nine-level noise-shaping modulator and a unit-element DAC made of equal-weight elements. On each sample strobe it turns the signed modulator level into a count of elements to switch on. It then picks which elements carry that count. The chosen elements form a contiguous run that starts at a rotation pointer kept in a register. After each sample the pointer moves past the last element used. Over time every element is used almost equally often, so the error from element mismatch is pushed towards high frequency and does not stay at a fixed level.

The count first becomes a thermometer pattern, with the low bits set. A barrel rotator then shifts that pattern left by the pointer value. The rotated pattern is captured into the output register on the strobe, and the pointer advances by the count, modulo the number of elements, on the same edge. Between strobes both the output and the pointer hold their values.

Top module: `dwa_selector`

## Requirements
- R1: A synchronous active-high reset clears every bit of `elem_en` to 0 and sets the rotation pointer to element 0. The first sample after reset therefore starts at bit 0.
- R2: `level` is a two's-complement value from -NUM_ELEM/2 to +NUM_ELEM/2. With the default of 8 elements this is a 4-bit value from -4 to +4. After a strobe, exactly level+NUM_ELEM/2 bits of `elem_en` are set.
- R3: The set bits of `elem_en` form a run that is contiguous modulo NUM_ELEM. The run starts at bit index p, where p is the pointer value before the strobe, and goes upward: bit p, then p+1, and so on, wrapping from the top bit to bit 0.
- R4: On each strobe the pointer becomes (p + count) mod NUM_ELEM. The next sample's run therefore starts right after the last element of the previous run.
- R5: A full-scale level (count NUM_ELEM) sets every bit and leaves the pointer unchanged.
- R6: The lowest level (count 0) clears every bit and leaves the pointer unchanged.
- R7: While `sample_en` is low, `elem_en` and the pointer keep their values, whatever `level` does.
- R8: Count, for each element, how many times it has been enabled since reset. At every point these counts differ by at most 1 between any two elements.
- R9: `elem_en` changes only on the clock edge where `sample_en` is high. The new pattern appears after that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | Sample strobe; captures a new level |
| level | input | LEVEL_W (4) | Signed modulator level |
| elem_en | output | NUM_ELEM (8) | Registered enable vector, one bit per unit element |

## Verification
The assertions assume that `level` never goes outside the range -NUM_ELEM/2 to +NUM_ELEM/2 when a strobe is present. A level outside that range would give a count that the thermometer and the pointer arithmetic do not cover. The bench draws each random level as an integer from 0 to NUM_ELEM and subtracts NUM_ELEM/2, so every applied level is legal. The directed cases add both range ends, and they drive out-of-range values on `level` only while the strobe is low, where the value must be ignored.

// File: rtl/dwa_pkg.sv
package dwa_pkg;

  // Modular add of a count onto a pointer for a ring of n elements.
  // Valid for 0 <= ptr < n and 0 <= cnt <= n.
  function automatic int ring_add(input int ptr, input int cnt, input int n);
    int s;
    s = ptr + cnt;
    if (s >= n) s = s - n;
    return s;
  endfunction

  // Index of the element that lands on position pos after a left rotation by ptr.
  function automatic int ring_src(input int pos, input int ptr, input int n);
    int s;
    s = pos - ptr;
    if (s < 0) s = s + n;
    return s;
  endfunction

endpackage

// File: rtl/dwa_level_decode.sv
module dwa_level_decode #(
  parameter int NUM_ELEM = 8,
  parameter int LEVEL_W  = $clog2(NUM_ELEM/2 + 1) + 1,
  parameter int CNT_W    = $clog2(NUM_ELEM + 1)
) (
  input  logic signed [LEVEL_W-1:0] level_i,
  output logic        [CNT_W-1:0]   count_o,
  output logic        [NUM_ELEM-1:0] therm_o
);
  localparam int HALF = NUM_ELEM / 2;

  always_comb count_o = CNT_W'(int'(level_i) + HALF);

  // Thermometer pattern: the low count_o bits are set
  for (genvar g = 0; g < NUM_ELEM; g++) begin : g_therm
    assign therm_o[g] = (int'(count_o) > g);
  end

endmodule

// File: rtl/dwa_rotator.sv
module dwa_rotator #(
  parameter int NUM_ELEM = 8,
  parameter int PTR_W    = $clog2(NUM_ELEM)
) (
  input  logic [NUM_ELEM-1:0] therm_i,
  input  logic [PTR_W-1:0]    ptr_i,
  output logic [NUM_ELEM-1:0] rot_o
);
  import dwa_pkg::*;

  // Barrel rotation to the left by ptr_i, one mux per output bit
  for (genvar g = 0; g < NUM_ELEM; g++) begin : g_rot
    always_comb rot_o[g] = therm_i[PTR_W'(ring_src(g, int'(ptr_i), NUM_ELEM))];
  end

endmodule

// File: rtl/dwa_pointer.sv
module dwa_pointer #(
  parameter int NUM_ELEM = 8,
  parameter int PTR_W    = $clog2(NUM_ELEM),
  parameter int CNT_W    = $clog2(NUM_ELEM + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [PTR_W-1:0] ptr_o
);
  import dwa_pkg::*;

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_d;

  always_comb ptr_d = PTR_W'(ring_add(int'(ptr_q), int'(count_i), NUM_ELEM));

  always_ff @(posedge clk) begin
    if (rst)         ptr_q <= '0;
    else if (step_i) ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;

  AST_PTR_RESET: assert property (@(posedge clk) rst |=> ptr_q == '0); // R1
  AST_PTR_FULL_STAYS: assert property (@(posedge clk) disable iff (rst)
    (step_i && int'(count_i) == NUM_ELEM) |=> $stable(ptr_q)); // R5
  AST_PTR_EMPTY_STAYS: assert property (@(posedge clk) disable iff (rst)
    (step_i && count_i == '0) |=> $stable(ptr_q)); // R6
  AST_PTR_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(ptr_q)); // R7

endmodule

// File: rtl/dwa_selector.sv
module dwa_selector #(
  parameter int NUM_ELEM = 8,
  parameter int LEVEL_W  = $clog2(NUM_ELEM/2 + 1) + 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      sample_en,
  input  logic signed [LEVEL_W-1:0] level,
  output logic [NUM_ELEM-1:0]       elem_en
);
  localparam int PTR_W = $clog2(NUM_ELEM);
  localparam int CNT_W = $clog2(NUM_ELEM + 1);
  localparam int HALF  = NUM_ELEM / 2;

  logic [CNT_W-1:0]    count;
  logic [NUM_ELEM-1:0] therm;
  logic [NUM_ELEM-1:0] rotated;
  logic [PTR_W-1:0]    ptr;
  logic [NUM_ELEM-1:0] elem_en_q;

  dwa_level_decode #(.NUM_ELEM(NUM_ELEM), .LEVEL_W(LEVEL_W), .CNT_W(CNT_W)) u_decode (
    .level_i (level),
    .count_o (count),
    .therm_o (therm)
  );

  dwa_rotator #(.NUM_ELEM(NUM_ELEM), .PTR_W(PTR_W)) u_rotate (
    .therm_i (therm),
    .ptr_i   (ptr),
    .rot_o   (rotated)
  );

  dwa_pointer #(.NUM_ELEM(NUM_ELEM), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_pointer (
    .clk     (clk),
    .rst     (rst),
    .step_i  (sample_en),
    .count_i (count),
    .ptr_o   (ptr)
  );

  always_ff @(posedge clk) begin
    if (rst)            elem_en_q <= '0;
    else if (sample_en) elem_en_q <= rotated;
  end

  assign elem_en = elem_en_q;

  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (rst)
    sample_en |-> (int'(level) >= -HALF && int'(level) <= HALF)); // R2
  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> elem_en_q == '0); // R1
  AST_POPCOUNT: assert property (@(posedge clk) disable iff (rst)
    sample_en |=> $countones(elem_en_q) == int'($past(level)) + HALF); // R2
  AST_RUN_START: assert property (@(posedge clk) disable iff (rst)
    (sample_en && count != '0) |=> elem_en_q[$past(ptr)]); // R3
  AST_RUN_EDGE: assert property (@(posedge clk) disable iff (rst)
    (sample_en && count != '0 && int'(count) < NUM_ELEM)
      |=> !elem_en_q[PTR_W'((int'($past(ptr)) + NUM_ELEM - 1) % NUM_ELEM)]); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !sample_en |=> $stable(elem_en_q)); // R7

endmodule

// File: tb/tb_dwa_selector.sv
module tb_dwa_selector;
  localparam int CLK_PERIOD = 10;
  localparam int N          = 8;
  localparam int HALF       = N / 2;
  localparam int LW         = 4;
  localparam int WATCHDOG   = 100000;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 sample_en = 1'b0;
  logic signed [LW-1:0] level = '0;
  logic [N-1:0]         elem_en;

  int checks = 0;
  int fails  = 0;
  int ptr_m  = 0;
  int usage [N];
  bit done   = 1'b0;

  dwa_selector #(.NUM_ELEM(N), .LEVEL_W(LW)) dut (
    .clk       (clk),
    .rst       (rst),
    .sample_en (sample_en),
    .level     (level),
    .elem_en   (elem_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [N-1:0] exp_pattern(input int cnt, input int p);
    logic [N-1:0] v = '0;
    for (int k = 0; k < cnt; k++) v[(p + k) % N] = 1'b1;
    return v;
  endfunction

  function automatic int popc(input logic [N-1:0] v);
    int c = 0;
    for (int k = 0; k < N; k++) c += int'(v[k]);
    return c;
  endfunction

  task automatic check_vec(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: elem_en actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_model();
    ptr_m = 0;
    for (int k = 0; k < N; k++) usage[k] = 0;
  endtask

  // One strobe; the output is valid after the next falling edge (R9)
  task automatic sample(input int lvl);
    int cnt = lvl + HALF;
    logic [N-1:0] exp;
    int mx, mn;
    @(negedge clk);
    level = LW'(lvl);
    sample_en = 1'b1;
    @(negedge clk);
    sample_en = 1'b0;
    exp = exp_pattern(cnt, ptr_m);
    check_int("R2 popcount", popc(elem_en), cnt);
    check_vec("R3/R4 run position", elem_en, exp);
    for (int k = 0; k < N; k++) if (exp[k]) usage[k]++;
    ptr_m = (ptr_m + cnt) % N;
    mx = usage[0]; mn = usage[0];
    for (int k = 1; k < N; k++) begin
      if (usage[k] > mx) mx = usage[k];
      if (usage[k] < mn) mn = usage[k];
    end
    checks++;
    if (mx - mn > 1) begin
      fails++;
      $display("FAIL R8 usage spread: actual %0d expected <=1", mx - mn);
    end
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [N-1:0] held;
    void'($urandom(32'd20240917));
    clear_model();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_vec("R1 reset clears", elem_en, '0);

    // First sample starts at bit 0 (R1), then counts 3,2,5,4 wrap around (R3, R4)
    sample(-1); sample(-2); sample(1); sample(0);

    // Full scale keeps pointer (R5): all ones, then a run of 1 at same start
    sample(HALF);
    check_vec("R5 full scale", elem_en, '1);
    sample(-HALF + 1);
    // Empty level keeps pointer (R6)
    sample(-HALF);
    check_vec("R6 empty", elem_en, '0);
    sample(-HALF + 2);

    // Idle: output and pointer hold while level wanders, even out of range (R7)
    held = elem_en;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      level = LW'(k * 3 - 8);
    end
    @(negedge clk);
    check_vec("R7 hold without strobe", elem_en, held);
    sample(-1);

    // Constrained random levels
    for (int k = 0; k < 400; k++) sample(int'($urandom_range(N, 0)) - HALF);

    // Reset mid-run restores pointer 0 (R1)
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_vec("R1 mid-run reset clears", elem_en, '0);
    clear_model();
    sample(-1);
    check_vec("R1 restart at bit 0", elem_en, 8'b0000_0111);
    for (int k = 0; k < 40; k++) sample(int'($urandom_range(N, 0)) - HALF);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule